// File: doc/BRIEF.md
# Short/Long Channel Switch Matrix

This block is the programmable routing point at one grid location of a simple logic fabric. Four sides meet at the matrix: north, east, south and west. Each side carries a set of short channels and an equal number of long channels. Short channels run to the adjacent matrix. Long channels skip to every other matrix. Every wire is modelled as a directional input with a matching output and output enable, so a route reads one wire and drives others.

Routing follows one rule. A route may only join wires that share a channel index. Within an index, a short wire may hand over to the long wire with the same index, on the same side or on other sides. Each index has its own configuration word. The word names one source wire and a set of destination wires, so no other connection can be configured.

One logic block attaches directly to the matrix. Its outputs can be placed on the short channels of one selected side. Its inputs read the short channels of that same side. The configuration is loaded serially through a shift chain. While the chain is shifting, every output enable stays low.

Top module: `sm_switch_matrix`

## Requirements
- R1: After the asynchronous active-low reset, every output enable and every output wire is 0, `conflict_o` is 0, and the whole configuration is cleared.
- R2: While `cfg_load_i` is high, the chain shifts once per clock: `cfg_data_i` enters bit 0 and `cfg_data_o` shows the top bit. The image is CFG_W = 2 + 13·NUM_CH bits wide, so a bit appears at `cfg_data_o` CFG_W clocks after it enters. During loading, all output enables and all output wires are 0 and `conflict_o` is 0.
- R3: The configuration image has a fixed layout. Bits [1:0] hold the side the logic block uses. Channel index c owns bits [2+13c +: 13], laid out as follows:
  - bit 0: route enable
  - bits 2:1: source side
  - bit 3: source is long
  - bits 7:4: short destination side mask
  - bits 11:8: long destination side mask
  - bit 12: logic-block inject enable

  Sides are numbered north=0, east=1, south=2, west=3. A wire of side s and index c sits at flat bit s·NUM_CH+c.
- R4: When the route of index c is enabled, each destination short wire of index c is driven (enable 1) with the value of the selected source wire of index c. The source wire may be short or long.
- R5: Long destination wires of index c are driven in the same way. This covers the hand-over from a short wire to a long wire, and from a long wire to a short wire, on the same side or on another side.
- R6: The wire a route reads from is never driven back, even when its side and type are named as a destination.
- R7: With inject enabled for index c, short wire c of the logic-block side is driven with `lb_out_i[c]`.
- R8: When a route and an injection both target the same short wire, that wire is driven to 0 with its enable high, and `conflict_o` is 1.
- R9: Any output wire whose enable is low is 0.
- R10: `lb_in_o[c]` equals the short input wire of index c on the logic-block side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_load_i | input | 1 | Shift-chain enable; all outputs disabled while high |
| cfg_data_i | input | 1 | Serial configuration in |
| cfg_data_o | output | 1 | Serial configuration out (chain tail) |
| short_in_i | input | 4·NUM_CH | Short channel inputs, side-major |
| long_in_i | input | 4·NUM_CH | Long channel inputs, side-major |
| short_out_o | output | 4·NUM_CH | Short channel outputs |
| short_oe_o | output | 4·NUM_CH | Short channel output enables |
| long_out_o | output | 4·NUM_CH | Long channel outputs |
| long_oe_o | output | 4·NUM_CH | Long channel output enables |
| lb_out_i | input | NUM_CH | Logic-block outputs to inject |
| lb_in_o | output | NUM_CH | Logic-block inputs from short channels |
| conflict_o | output | 1 | A short wire has two drivers |

## Verification
The hardest situations to reach from the ports depend on a full serial load:
- a route that names its own source wire as a destination;
- a route and an injection that land on the same short wire.

Both exist only after the whole image has been shifted in. The stimulus first builds such images directly, one for the self-loop with hand-over and one for the conflict, and drives 1s on the inputs so that a suppressed drive is visible. Random images then follow, each checked under several random input patterns. Checks are also made part-way through a load, and while the old image is being shifted out.

// File: rtl/sm_pkg.sv
package sm_pkg;
  localparam int NUM_SIDES = 4;
  localparam int SIDE_W    = 2;

  typedef struct packed {
    logic                 inj_en;
    logic [NUM_SIDES-1:0] dst_long;
    logic [NUM_SIDES-1:0] dst_short;
    logic                 src_long;
    logic [SIDE_W-1:0]    src_side;
    logic                 route_en;
  } lane_cfg_t;

  localparam int LANE_CFG_W = $bits(lane_cfg_t);
endpackage

// File: rtl/sm_cfg_chain.sv
module sm_cfg_chain #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         data_i,
  output logic [W-1:0] cfg_o,
  output logic         data_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[W-2:0], data_i};
  end

  assign cfg_o  = sr_q;
  assign data_o = sr_q[W-1];
endmodule

// File: rtl/sm_lane.sv
module sm_lane
  import sm_pkg::*;
(
  input  logic                 active_i,
  input  lane_cfg_t            cfg_i,
  input  logic [SIDE_W-1:0]    lb_side_i,
  input  logic                 lb_out_i,
  input  logic [NUM_SIDES-1:0] short_in_i,
  input  logic [NUM_SIDES-1:0] long_in_i,
  output logic [NUM_SIDES-1:0] short_out_o,
  output logic [NUM_SIDES-1:0] short_oe_o,
  output logic [NUM_SIDES-1:0] long_out_o,
  output logic [NUM_SIDES-1:0] long_oe_o,
  output logic                 conflict_o
);
  logic                 src_val;
  logic [NUM_SIDES-1:0] rte_s, rte_l, inj;

  assign src_val = cfg_i.src_long ? long_in_i[cfg_i.src_side] : short_in_i[cfg_i.src_side];

  always_comb begin
    for (int d = 0; d < NUM_SIDES; d++) begin
      // never drive the wire the route reads from
      rte_s[d] = active_i && cfg_i.route_en && cfg_i.dst_short[d] &&
                 !(!cfg_i.src_long && cfg_i.src_side == SIDE_W'(d));
      rte_l[d] = active_i && cfg_i.route_en && cfg_i.dst_long[d] &&
                 !(cfg_i.src_long && cfg_i.src_side == SIDE_W'(d));
      inj[d]   = active_i && cfg_i.inj_en && lb_side_i == SIDE_W'(d);
      short_oe_o[d]  = rte_s[d] | inj[d];
      short_out_o[d] = (rte_s[d] && !inj[d]) ? src_val :
                       (inj[d] && !rte_s[d]) ? lb_out_i : 1'b0;
      long_oe_o[d]   = rte_l[d];
      long_out_o[d]  = rte_l[d] & src_val;
    end
  end

  assign conflict_o = |(rte_s & inj);
endmodule

// File: rtl/sm_switch_matrix.sv
module sm_switch_matrix
  import sm_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cfg_load_i,
  input  logic                        cfg_data_i,
  output logic                        cfg_data_o,
  input  logic [NUM_SIDES*NUM_CH-1:0] short_in_i,
  input  logic [NUM_SIDES*NUM_CH-1:0] long_in_i,
  output logic [NUM_SIDES*NUM_CH-1:0] short_out_o,
  output logic [NUM_SIDES*NUM_CH-1:0] short_oe_o,
  output logic [NUM_SIDES*NUM_CH-1:0] long_out_o,
  output logic [NUM_SIDES*NUM_CH-1:0] long_oe_o,
  input  logic [NUM_CH-1:0]           lb_out_i,
  output logic [NUM_CH-1:0]           lb_in_o,
  output logic                        conflict_o
);
  localparam int CFG_W = SIDE_W + NUM_CH * LANE_CFG_W;

  logic [CFG_W-1:0]  cfg;
  logic [SIDE_W-1:0] lb_side;
  logic              active;
  logic [NUM_CH-1:0] lane_conf;

  sm_cfg_chain #(.W(CFG_W)) u_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (cfg_load_i),
    .data_i  (cfg_data_i),
    .cfg_o   (cfg),
    .data_o  (cfg_data_o)
  );

  assign lb_side = cfg[SIDE_W-1:0];
  assign active  = !cfg_load_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    logic [NUM_SIDES-1:0] s_in, l_in, s_out, s_oe, l_out, l_oe;

    for (genvar d = 0; d < NUM_SIDES; d++) begin : g_side
      assign s_in[d]                    = short_in_i[d*NUM_CH+c];
      assign l_in[d]                    = long_in_i[d*NUM_CH+c];
      assign short_out_o[d*NUM_CH+c]    = s_out[d];
      assign short_oe_o[d*NUM_CH+c]     = s_oe[d];
      assign long_out_o[d*NUM_CH+c]     = l_out[d];
      assign long_oe_o[d*NUM_CH+c]      = l_oe[d];
    end

    sm_lane u_lane (
      .active_i    (active),
      .cfg_i       (lane_cfg_t'(cfg[SIDE_W+c*LANE_CFG_W +: LANE_CFG_W])),
      .lb_side_i   (lb_side),
      .lb_out_i    (lb_out_i[c]),
      .short_in_i  (s_in),
      .long_in_i   (l_in),
      .short_out_o (s_out),
      .short_oe_o  (s_oe),
      .long_out_o  (l_out),
      .long_oe_o   (l_oe),
      .conflict_o  (lane_conf[c])
    );

    assign lb_in_o[c] = s_in[lb_side];
  end

  assign conflict_o = |lane_conf;
endmodule

// File: rtl/sm_switch_matrix_chk.sv
module sm_switch_matrix_chk #(
  parameter int WIRES = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_load_i,
  input logic             cfg_data_o,
  input logic [WIRES-1:0] short_out_o,
  input logic [WIRES-1:0] short_oe_o,
  input logic [WIRES-1:0] long_out_o,
  input logic [WIRES-1:0] long_oe_o,
  input logic             conflict_o
);
  AST_LOAD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_load_i |-> (short_oe_o == '0 && long_oe_o == '0 && !conflict_o)); // R2

  AST_CHAIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cfg_load_i) |-> $stable(cfg_data_o)); // R2

  AST_SHORT_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (short_out_o & ~short_oe_o) == '0); // R9

  AST_LONG_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (long_out_o & ~long_oe_o) == '0); // R9
endmodule

bind sm_switch_matrix sm_switch_matrix_chk #(.WIRES(sm_pkg::NUM_SIDES*NUM_CH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_load_i  (cfg_load_i),
  .cfg_data_o  (cfg_data_o),
  .short_out_o (short_out_o),
  .short_oe_o  (short_oe_o),
  .long_out_o  (long_out_o),
  .long_oe_o   (long_oe_o),
  .conflict_o  (conflict_o)
);

// File: tb/sm_switch_matrix_tb_top.sv
module sm_switch_matrix_tb_top;
  localparam int NCH   = 4;
  localparam int NW    = 4 * NCH;
  localparam int LW    = 13;
  localparam int CFG_W = 2 + NCH * LW;

  logic clk_i = 0, rst_ni = 0, cfg_load_i = 0, cfg_data_i = 0, cfg_data_o, conflict_o;
  logic [NW-1:0] short_in_i = '0, long_in_i = '0, short_out_o, short_oe_o, long_out_o, long_oe_o;
  logic [NCH-1:0] lb_out_i = '0, lb_in_o;

  int n_cmp = 0, n_bad = 0;
  logic [CFG_W-1:0] cur_cfg = '0;

  always #4 clk_i = ~clk_i;

  sm_switch_matrix #(.NUM_CH(NCH)) dut_i (.*);

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic chk(string tag, logic [NW-1:0] act, logic [NW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected outputs from the requirements (R3..R10)
  task automatic model(input logic [CFG_W-1:0] cfg, output logic [NW-1:0] so, soe, lo, loe,
                       output logic [NCH-1:0] lbi, output logic conf);
    logic [1:0] lbs;
    so = '0; soe = '0; lo = '0; loe = '0; conf = 0;
    lbs = cfg[1:0];
    for (int c = 0; c < NCH; c++) begin
      logic [LW-1:0] w;
      logic v, rs, rl, ij;
      w = cfg[2+c*LW +: LW];
      v = w[3] ? long_in_i[w[2:1]*NCH+c] : short_in_i[w[2:1]*NCH+c];
      lbi[c] = short_in_i[lbs*NCH+c];
      for (int d = 0; d < 4; d++) begin
        rs = w[0] && w[4+d] && !(!w[3] && w[2:1] == 2'(d));
        rl = w[0] && w[8+d] && !(w[3] && w[2:1] == 2'(d));
        ij = w[12] && lbs == 2'(d);
        if (rs && ij) begin soe[d*NCH+c] = 1; conf = 1; end
        else if (rs) begin soe[d*NCH+c] = 1; so[d*NCH+c] = v; end
        else if (ij) begin soe[d*NCH+c] = 1; so[d*NCH+c] = lb_out_i[c]; end
        if (rl) begin loe[d*NCH+c] = 1; lo[d*NCH+c] = v; end
      end
    end
  endtask

  task automatic check_all();
    logic [NW-1:0] so, soe, lo, loe;
    logic [NCH-1:0] lbi;
    logic conf;
    model(cur_cfg, so, soe, lo, loe, lbi, conf);
    #1;
    chk("R4 short out", short_out_o, so);
    chk("R4 short oe", short_oe_o, soe);
    chk("R5 long out", long_out_o, lo);
    chk("R5 long oe", long_oe_o, loe);
    chk("R10 lb in", NW'(lb_in_o), NW'(lbi));
    chk("R8 conflict", NW'(conflict_o), NW'(conf));
  endtask

  // MSB first so the image lands with bit 0 at chain bit 0; check old image coming out
  task automatic load(logic [CFG_W-1:0] v);
    cfg_load_i = 1;
    for (int b = CFG_W - 1; b >= 0; b--) begin
      cfg_data_i = v[b];
      #1;
      chk("R2 chain out", NW'(cfg_data_o), NW'(cur_cfg[b]));
      if (b == CFG_W / 2) begin
        chk("R2 oe quiet", short_oe_o | long_oe_o, '0);
        chk("R2 out quiet", short_out_o | long_out_o, '0);
        chk("R2 conflict quiet", NW'(conflict_o), '0);
      end
      @(posedge clk_i);
      #1;
    end
    cfg_load_i = 0;
    cur_cfg = v;
  endtask

  function automatic logic [LW-1:0] lane(logic inj, logic [3:0] dl, logic [3:0] ds,
                                         logic sl, logic [1:0] ss, logic en);
    return {inj, dl, ds, sl, ss, en};
  endfunction

  initial begin
    logic [CFG_W-1:0] v;
    void'($urandom(32'd2024));
    short_in_i = '1; long_in_i = '1; lb_out_i = '1;
    #3;
    chk("R1 reset short oe", short_oe_o, '0);
    chk("R1 reset long oe", long_oe_o, '0);
    chk("R1 reset outs", short_out_o | long_out_o, '0);
    chk("R1 reset conflict", NW'(conflict_o), '0);
    #10 rst_ni = 1;
    @(posedge clk_i); #1;
    check_all();

    // R6: index 0 reads north short, dest all short sides + north long (hand-over)
    v = '0;
    v[2 +: LW] = lane(0, 4'b0001, 4'b1111, 0, 2'd0, 1);
    load(v);
    check_all();
    chk("R6 source not driven", NW'(short_oe_o[0]), '0);
    chk("R5 handover north long", NW'(long_out_o[0]), NW'(1'b1));
    chk("R9 unused wires", short_oe_o & ~NW'(16'h1110), '0);

    // R8: index 1 west long -> east short, injection on east
    v = '0;
    v[1:0] = 2'd1;
    v[2+LW +: LW] = lane(1, 4'b0000, 4'b0010, 1, 2'd3, 1);
    load(v);
    check_all();
    chk("R8 conflict flag", NW'(conflict_o), NW'(1'b1));
    chk("R8 wire zero", NW'(short_out_o[1*NCH+1]), '0);

    // R7: injection only on south for index 2 and 3
    v = '0;
    v[1:0] = 2'd2;
    v[2+2*LW +: LW] = lane(1, 0, 0, 0, 0, 0);
    v[2+3*LW +: LW] = lane(1, 0, 0, 0, 0, 0);
    load(v);
    lb_out_i = 4'b0100;
    check_all();
    chk("R7 inject", short_out_o & NW'(16'h0C00), NW'(16'h0400));

    for (int k = 0; k < 60; k++) begin
      for (int i = 0; i < CFG_W; i++) v[i] = 1'($urandom);
      load(v);
      for (int p = 0; p < 5; p++) begin
        short_in_i = NW'($urandom);
        long_in_i  = NW'($urandom);
        lb_out_i   = NCH'($urandom);
        check_all();
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule